// File: doc/BRIEF.md
# Exception Entry Vector Unit

This unit performs the architectural state changes that a processor makes when it takes an exception. A request arrives as a single beat carrying a 12-bit exception code together with a snapshot of the interrupted context: the status word, the program counter, the vector base and general register 15. In the cycle the beat is accepted, the unit saves that context into shadow registers, forces the block, privileged-mode and register-bank bits of the status word, records the event code and computes the handler address.

The handler address depends on the class of the code. The three translation-miss codes branch to the vector base plus 0x400. The multiple-hit code branches to a fixed absolute address that ignores the vector base. Every other code branches to the vector base plus 0x100. Classification uses all 12 bits of the code, while the recorded event value keeps only the low 11.

The request side is a valid/ready stream. The unit never applies back-pressure once out of reset, so a producer may present one beat per cycle, back to back. A beat is consumed on a rising edge where both valid and ready are high. Results appear on the registered outputs one cycle later and hold until the next accepted beat.

Top module: `exc_entry_unit`

## Requirements
- R1: On an accepted beat, `sts_save` takes `ctx_sts` and `stk_save` takes `ctx_r15`, visible the cycle after.
- R2: On an accepted beat, `pc_save` takes `ctx_pc`, visible the cycle after.
- R3: On an accepted beat, `sts_o` becomes `ctx_sts` with bits 30 (privileged mode), 29 (register bank) and 28 (block) forced to 1 and all other bits unchanged.
- R4: On an accepted beat, `evt_o` becomes `req_code & 12'h7FF`.
- R5: Codes 12'h040, 12'h060 and 12'h080 set `pc_o` to `ctx_vbr + 32'h400`, wrapping modulo 2^32.
- R6: Code 12'h140 sets `pc_o` to 32'hA000_0000, whatever the value of `ctx_vbr`.
- R7: Every other code sets `pc_o` to `ctx_vbr + 32'h100`, wrapping modulo 2^32. This includes codes such as 12'h840 or 12'h940, whose low 11 bits match a special code.
- R8: In a cycle with `req_valid` low, no output changes, whatever the other inputs do.
- R9: While `rst` is high at a clock edge, `sts_o` becomes 32'h7000_00F0, `pc_o` becomes 32'hA000_0000, and `sts_save`, `pc_save`, `stk_save` and `evt_o` become 0.
- R10: `req_ready` is 0 while `rst` is high and 1 otherwise, so a new beat can be taken every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Exception request beat present |
| req_ready | output | 1 | Unit can take a beat |
| req_code | input | 12 | Exception code |
| ctx_sts | input | 32 | Status word at the point of interruption |
| ctx_pc | input | 32 | Interrupted program counter |
| ctx_vbr | input | 32 | Vector base |
| ctx_r15 | input | 32 | General register 15 |
| sts_o | output | 32 | Status word after entry |
| sts_save | output | 32 | Saved status word |
| pc_save | output | 32 | Saved program counter |
| stk_save | output | 32 | Saved register 15 |
| evt_o | output | 12 | Recorded event code |
| pc_o | output | 32 | Handler program counter |

## Verification
The properties assume that reset is held for at least two edges before the first beat, so that every `$past` and `$stable` comparison sees defined register values. They also assume that the context inputs are stable across the accepting edge. The bench meets both conditions: it holds reset for four cycles and changes every input only on the falling edge. It mixes random codes with the special codes, their 11-bit aliases and vector bases near the top of the address space. Idle cycles carry random input values, so that the hold property sees real input changes.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    VC_GENERAL = 2'd0,
    VC_TLB     = 2'd1,
    VC_FIXED   = 2'd2
  } vec_class_e;

endpackage

// File: rtl/exc_vec_class.sv
module exc_vec_class
  import exc_entry_pkg::*;
#(
  parameter int                          CODE_W     = 12,
  parameter int                          NUM_TLB    = 3,
  parameter logic [NUM_TLB*CODE_W-1:0]   TLB_CODES  = {12'h080, 12'h060, 12'h040},
  parameter logic [CODE_W-1:0]           FIXED_CODE = 12'h140
) (
  input  logic [CODE_W-1:0] code_i,
  output vec_class_e        class_o
);

  logic [NUM_TLB-1:0] tlb_hit;

  // One comparator per translation-miss code, over the full code width
  for (genvar g = 0; g < NUM_TLB; g++) begin : g_tlb_cmp
    assign tlb_hit[g] = (code_i == TLB_CODES[g*CODE_W +: CODE_W]);
  end

  always_comb begin
    if (code_i == FIXED_CODE)
      class_o = VC_FIXED;
    else if (|tlb_hit)
      class_o = VC_TLB;
    else
      class_o = VC_GENERAL;
  end

endmodule

// File: rtl/exc_target_sel.sv
module exc_target_sel
  import exc_entry_pkg::*;
#(
  parameter int               XLEN      = 32,
  parameter logic [XLEN-1:0]  TLB_OFS   = 32'h0000_0400,
  parameter logic [XLEN-1:0]  GEN_OFS   = 32'h0000_0100,
  parameter logic [XLEN-1:0]  FIXED_VEC = 32'hA000_0000
) (
  input  vec_class_e       class_i,
  input  logic [XLEN-1:0]  vbr_i,
  output logic [XLEN-1:0]  target_o
);

  logic [XLEN-1:0] tlb_tgt;
  logic [XLEN-1:0] gen_tgt;

  assign tlb_tgt = vbr_i + TLB_OFS;
  assign gen_tgt = vbr_i + GEN_OFS;

  always_comb begin
    unique case (class_i)
      VC_TLB:   target_o = tlb_tgt;
      VC_FIXED: target_o = FIXED_VEC;
      default:  target_o = gen_tgt;
    endcase
  end

endmodule

// File: rtl/exc_sts_force.sv
module exc_sts_force #(
  parameter int XLEN      = 32,
  parameter int MODE_BIT  = 30,
  parameter int BANK_BIT  = 29,
  parameter int BLOCK_BIT = 28
) (
  input  logic [XLEN-1:0] sts_i,
  output logic [XLEN-1:0] sts_o
);

  // Per-bit selection: forced bits go high, the rest pass through
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (b == MODE_BIT || b == BANK_BIT || b == BLOCK_BIT) begin : g_force
      assign sts_o[b] = 1'b1;
    end else begin : g_pass
      assign sts_o[b] = sts_i[b];
    end
  end

endmodule

// File: rtl/exc_hold_reg.sv
module exc_hold_reg #(
  parameter int             W   = 32,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  d,
  output logic [W-1:0]  q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= RST;
    else if (load)
      q <= d;
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int                          XLEN       = 32,
  parameter int                          CODE_W     = 12,
  parameter int                          MODE_BIT   = 30,
  parameter int                          BANK_BIT   = 29,
  parameter int                          BLOCK_BIT  = 28,
  parameter logic [CODE_W-1:0]           EVT_MASK   = 12'h7FF,
  parameter int                          NUM_TLB    = 3,
  parameter logic [NUM_TLB*CODE_W-1:0]   TLB_CODES  = {12'h080, 12'h060, 12'h040},
  parameter logic [CODE_W-1:0]           FIXED_CODE = 12'h140,
  parameter logic [XLEN-1:0]             TLB_OFS    = 32'h0000_0400,
  parameter logic [XLEN-1:0]             GEN_OFS    = 32'h0000_0100,
  parameter logic [XLEN-1:0]             FIXED_VEC  = 32'hA000_0000,
  parameter logic [XLEN-1:0]             STS_RST    = 32'h7000_00F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic [XLEN-1:0]   ctx_sts,
  input  logic [XLEN-1:0]   ctx_pc,
  input  logic [XLEN-1:0]   ctx_vbr,
  input  logic [XLEN-1:0]   ctx_r15,
  output logic [XLEN-1:0]   sts_o,
  output logic [XLEN-1:0]   sts_save,
  output logic [XLEN-1:0]   pc_save,
  output logic [XLEN-1:0]   stk_save,
  output logic [CODE_W-1:0] evt_o,
  output logic [XLEN-1:0]   pc_o
);

  localparam logic [XLEN-1:0]   ZERO_X = '0;
  localparam logic [CODE_W-1:0] ZERO_C = '0;

  logic            take;
  vec_class_e      vclass;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] sts_next;
  logic [CODE_W-1:0] evt_next;

  assign req_ready = ~rst;
  assign take      = req_valid & req_ready;
  assign evt_next  = req_code & EVT_MASK;

  exc_vec_class #(
    .CODE_W    (CODE_W),
    .NUM_TLB   (NUM_TLB),
    .TLB_CODES (TLB_CODES),
    .FIXED_CODE(FIXED_CODE)
  ) u_class (
    .code_i (req_code),
    .class_o(vclass)
  );

  exc_target_sel #(
    .XLEN     (XLEN),
    .TLB_OFS  (TLB_OFS),
    .GEN_OFS  (GEN_OFS),
    .FIXED_VEC(FIXED_VEC)
  ) u_target (
    .class_i (vclass),
    .vbr_i   (ctx_vbr),
    .target_o(target)
  );

  exc_sts_force #(
    .XLEN     (XLEN),
    .MODE_BIT (MODE_BIT),
    .BANK_BIT (BANK_BIT),
    .BLOCK_BIT(BLOCK_BIT)
  ) u_force (
    .sts_i(ctx_sts),
    .sts_o(sts_next)
  );

  exc_hold_reg #(.W(XLEN), .RST(STS_RST)) u_sts_q (
    .clk(clk), .rst(rst), .load(take), .d(sts_next), .q(sts_o));

  exc_hold_reg #(.W(XLEN), .RST(ZERO_X)) u_ssave_q (
    .clk(clk), .rst(rst), .load(take), .d(ctx_sts), .q(sts_save));

  exc_hold_reg #(.W(XLEN), .RST(ZERO_X)) u_psave_q (
    .clk(clk), .rst(rst), .load(take), .d(ctx_pc), .q(pc_save));

  exc_hold_reg #(.W(XLEN), .RST(ZERO_X)) u_ksave_q (
    .clk(clk), .rst(rst), .load(take), .d(ctx_r15), .q(stk_save));

  exc_hold_reg #(.W(CODE_W), .RST(ZERO_C)) u_evt_q (
    .clk(clk), .rst(rst), .load(take), .d(evt_next), .q(evt_o));

  exc_hold_reg #(.W(XLEN), .RST(FIXED_VEC)) u_pc_q (
    .clk(clk), .rst(rst), .load(take), .d(target), .q(pc_o));

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN      = 32,
  parameter int CODE_W    = 12,
  parameter int MODE_BIT  = 30,
  parameter int BANK_BIT  = 29,
  parameter int BLOCK_BIT = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CODE_W-1:0] req_code,
  input logic [XLEN-1:0]   ctx_sts,
  input logic [XLEN-1:0]   ctx_pc,
  input logic [XLEN-1:0]   ctx_vbr,
  input logic [XLEN-1:0]   ctx_r15,
  input logic [XLEN-1:0]   sts_o,
  input logic [XLEN-1:0]   sts_save,
  input logic [XLEN-1:0]   pc_save,
  input logic [XLEN-1:0]   stk_save,
  input logic [CODE_W-1:0] evt_o,
  input logic [XLEN-1:0]   pc_o
);

  logic acc;
  assign acc = req_valid && req_ready;

  p_ctx_save_r1: assert property (@(posedge clk) disable iff (rst)
    acc |=> (sts_save == $past(ctx_sts)) && (stk_save == $past(ctx_r15)));

  p_pc_save_r2: assert property (@(posedge clk) disable iff (rst)
    acc |=> pc_save == $past(ctx_pc));

  p_sts_force_r3: assert property (@(posedge clk) disable iff (rst)
    acc |=> sts_o[MODE_BIT] && sts_o[BANK_BIT] && sts_o[BLOCK_BIT]);

  p_evt_mask_r4: assert property (@(posedge clk) disable iff (rst)
    acc |=> evt_o == ($past(req_code) & 12'h7FF));

  p_tlb_vec_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && (req_code == 12'h040 || req_code == 12'h060 || req_code == 12'h080))
      |=> pc_o == $past(ctx_vbr) + 32'h400);

  p_fixed_vec_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && req_code == 12'h140) |=> pc_o == 32'hA000_0000);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(sts_o) && $stable(sts_save) && $stable(pc_save)
                   && $stable(stk_save) && $stable(evt_o) && $stable(pc_o));

  p_ready_r10: assert property (@(posedge clk) req_ready == !rst);

endmodule

bind exc_entry_unit exc_entry_chk #(
  .XLEN(XLEN), .CODE_W(CODE_W), .MODE_BIT(MODE_BIT),
  .BANK_BIT(BANK_BIT), .BLOCK_BIT(BLOCK_BIT)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_code(req_code), .ctx_sts(ctx_sts), .ctx_pc(ctx_pc),
  .ctx_vbr(ctx_vbr), .ctx_r15(ctx_r15), .sts_o(sts_o),
  .sts_save(sts_save), .pc_save(pc_save), .stk_save(stk_save),
  .evt_o(evt_o), .pc_o(pc_o)
);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_code = '0;
  logic [31:0] ctx_sts = '0, ctx_pc = '0, ctx_vbr = '0, ctx_r15 = '0;
  logic [31:0] sts_o, sts_save, pc_save, stk_save, pc_o;
  logic [11:0] evt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // expected state
  logic [31:0] e_sts, e_ssave, e_psave, e_ksave, e_pc;
  logic [11:0] e_evt;

  always #10 clk = ~clk;

  exc_entry_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .ctx_sts(ctx_sts), .ctx_pc(ctx_pc),
    .ctx_vbr(ctx_vbr), .ctx_r15(ctx_r15), .sts_o(sts_o),
    .sts_save(sts_save), .pc_save(pc_save), .stk_save(stk_save),
    .evt_o(evt_o), .pc_o(pc_o)
  );

  function automatic logic [31:0] f_target(logic [11:0] c, logic [31:0] vbr);
    if (c == 12'h140) return 32'hA000_0000;
    if (c == 12'h040 || c == 12'h060 || c == 12'h080) return vbr + 32'h400;
    return vbr + 32'h100;
  endfunction

  function automatic logic [31:0] f_sts(logic [31:0] s);
    return s | 32'h7000_0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " R1 sts_save"}, sts_save, e_ssave);
    chk({tag, " R1 stk_save"}, stk_save, e_ksave);
    chk({tag, " R2 pc_save"}, pc_save, e_psave);
    chk({tag, " R3 sts_o"}, sts_o, e_sts);
    chk({tag, " R4 evt_o"}, {20'd0, evt_o}, {20'd0, e_evt});
    chk({tag, " R5/R6/R7 pc_o"}, pc_o, e_pc);
  endtask

  task automatic send(logic [11:0] c, logic [31:0] s, logic [31:0] p,
                      logic [31:0] v, logic [31:0] r);
    req_valid = 1'b1; req_code = c;
    ctx_sts = s; ctx_pc = p; ctx_vbr = v; ctx_r15 = r;
    e_sts = f_sts(s); e_ssave = s; e_psave = p; e_ksave = r;
    e_evt = c & 12'h7FF; e_pc = f_target(c, v);
    @(negedge clk);
    chk_all("event");
  endtask

  task automatic idle();
    req_valid = 1'b0;
    req_code = 12'($urandom); ctx_sts = $urandom; ctx_pc = $urandom;
    ctx_vbr = $urandom; ctx_r15 = $urandom;
    @(negedge clk);
    chk_all("R8 idle");
  endtask

  function automatic logic [11:0] pick_code();
    case ($urandom % 8)
      0: return 12'h040;
      1: return 12'h060;
      2: return 12'h080;
      3: return 12'h140;
      4: return 12'h840;   // alias of a miss code, general class
      5: return 12'h940;   // alias of the fixed code, general class
      default: return 12'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R9 reset values, R10 ready low in reset
    chk("R9 sts_o reset", sts_o, 32'h7000_00F0);
    chk("R9 pc_o reset", pc_o, 32'hA000_0000);
    chk("R9 sts_save reset", sts_save, 32'h0);
    chk("R9 pc_save reset", pc_save, 32'h0);
    chk("R9 stk_save reset", stk_save, 32'h0);
    chk("R9 evt_o reset", {20'd0, evt_o}, 32'h0);
    chk("R10 ready in reset", {31'd0, req_ready}, 32'h0);
    rst = 1'b0;
    #1;
    chk("R10 ready after reset", {31'd0, req_ready}, 32'h1);
    e_sts = 32'h7000_00F0; e_pc = 32'hA000_0000;
    e_ssave = '0; e_psave = '0; e_ksave = '0; e_evt = '0;
    @(negedge clk);
    chk_all("R8 idle after reset");

    // directed corner cases
    send(12'h040, 32'h0000_0000, 32'h1000_0000, 32'h8000_0000, 32'h1111_1111); // R5
    send(12'h060, 32'h8FFF_FFFF, 32'h2000_0000, 32'hFFFF_FE00, 32'h2222_2222); // R5 wrap
    send(12'h080, 32'h0000_00F0, 32'h3000_0000, 32'h0C00_0000, 32'h3333_3333); // R5
    send(12'h140, 32'h1234_5678, 32'h4000_0000, 32'h5555_0000, 32'h4444_4444); // R6
    send(12'h140, 32'h0, 32'h4000_0004, 32'hFFFF_FFFF, 32'h0);                 // R6 vbr ignored
    send(12'h840, 32'h0, 32'h5000_0000, 32'h0000_1000, 32'h0);                 // R7 alias, R4 mask
    send(12'h940, 32'h0, 32'h5000_0004, 32'h0000_2000, 32'h0);                 // R7 alias
    send(12'hFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FF80, 32'hFFFF_FFFF); // R7 wrap, R4
    send(12'h0E0, 32'h8F00_0001, 32'h6000_0000, 32'h0000_0000, 32'h6666_6666); // R3 R7
    repeat (3) idle();                                                        // R8

    // random mix, back-to-back and idle cycles
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 4 == 0) idle();
      else send(pick_code(), $urandom, $urandom,
                (($urandom % 5) == 0) ? 32'hFFFF_FC00 | 32'($urandom % 1024) : $urandom,
                $urandom);
    end

    req_valid = 1'b0;
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule